// File: doc/BRIEF.md
# Pattern Sync and Error Detector

This block watches a received serial bit stream, one bit per cycle in which a strobe is high, and locks onto a test pattern. The pattern is either a short repeating word or a pseudo-random sequence from a configurable linear feedback shift register. The configuration is the same set of settings the matching transmit-side generator uses: mode, length, tap, pattern word and polarity. Once locked, the block compares every strobed bit with the value it predicts. For each checked bit it emits a one-cycle check strobe, and for each mismatch a one-cycle error pulse, so that external counters can work out a bit error ratio.

Loss of lock is judged over fixed windows of checked bits. Too many errors inside one window drop the lock. A new search then starts by itself, or waits for a rising edge on a manual restart input, depending on a mode input.

Top module: `pat_sync_det`

## Requirements
- R1: After reset, and while reset is held, `in_sync`, `bit_err` and `bit_chk` are 0, and the detector is searching.
- R2: When `cfg_inv` is 1, every received bit is complemented before any comparison. A complemented stream with `cfg_inv` at 0 never locks.
- R3: In pseudo-random mode (`cfg_prbs`=1) the sequence length is L=`cfg_len`+1. Each new bit equals bit `cfg_len` XOR bit `cfg_tap` of a register that holds the previous bits, with the newest bit in position 0. The detector seeds from the first L strobed bits and then needs 48 consecutive correct predictions, so `in_sync` is high in the cycle after strobed bit number `cfg_len`+49.
- R4: In repeating mode (`cfg_prbs`=0) the stream is `cfg_pat[0]`, `cfg_pat[1]` … `cfg_pat[cfg_len]`, then it wraps. An aligned stream locks after its 48th bit. In a misaligned stream, each mismatch during search slips the expected phase by one bit until a rotation gives 48 clean bits.
- R5: While locked, each strobed bit gives a one-cycle `bit_chk` pulse in the following cycle, and `bit_err` pulses with it exactly when the bit mismatches. In pseudo-random mode a single flipped bit causes exactly one error pulse.
- R6: Errors are counted in fixed windows of 48 checked bits, the first window starting at the first checked bit after lock. Up to 10 errors in a window keep the lock, even when two adjacent windows hold 6 errors each near their shared boundary.
- R7: The 11th error inside one window clears `in_sync` in the same cycle that its `bit_err` pulse is high.
- R8: With `auto_sync`=1, a loss of lock starts a new search at once. A clean pseudo-random stream relocks after `cfg_len`+49 further strobed bits.
- R9: With `auto_sync`=0, after a loss of lock the detector stays unlocked whatever bits arrive.
- R10: A rising edge of `man_sync` in any state restarts the search, so `in_sync` is 0 in the following cycle. Holding `man_sync` high has no further effect.
- R11: Cycles with `bit_en` low change neither the search, the lock nor the prediction, and produce no `bit_chk` or `bit_err` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Strobe: `rx_bit` is valid this cycle |
| rx_bit | input | 1 | Received serial data |
| cfg_prbs | input | 1 | 1 = pseudo-random mode, 0 = repeating word |
| cfg_len | input | 5 | Index of the top valid pattern bit (1..31) |
| cfg_tap | input | 5 | Feedback tap position, below `cfg_len` |
| cfg_pat | input | 32 | Repeating word (repeating mode only) |
| cfg_inv | input | 1 | Complement received data before comparing |
| auto_sync | input | 1 | Restart the search automatically on loss |
| man_sync | input | 1 | Manual search restart on rising edge |
| in_sync | output | 1 | Lock status level |
| bit_err | output | 1 | One-cycle pulse per errored checked bit |
| bit_chk | output | 1 | One-cycle pulse per checked bit while locked |

## Verification
The error pulse of the 11th bad bit in a window and the loss of lock it causes fall in the same clock cycle. The bench provokes this by flipping the first 11 bits of a fresh window. It then requires the sample after that bit to show `bit_err` high and `in_sync` low together, while the 10 earlier flips left the lock intact. The same run places 6 flips on each side of a window boundary, to show that the window count resets on time rather than merging the two windows into a loss.

// File: rtl/pat_sync_pkg.sv
package pat_sync_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_LOCK = 2'd1,
    ST_HOLD = 2'd2
  } det_state_e;
endpackage

// File: rtl/pat_sync_ref.sv
// Expected-bit source: self-seeding LFSR or rotating word pointer.
module pat_sync_ref #(
  parameter int PW = 32,
  localparam int LW = $clog2(PW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          rx_c,
  input  logic          prbs,
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] tap,
  input  logic [PW-1:0] pat,
  input  logic          load_rx,
  input  logic          restart,
  input  logic          slip,
  output logic          exp_bit,
  output logic          seeded
);
  logic [PW-1:0] lfsr;
  logic [LW-1:0] ptr;
  logic [LW:0]   fill;
  logic          prbs_exp;

  assign prbs_exp = lfsr[len] ^ lfsr[tap];
  assign exp_bit  = prbs ? prbs_exp : pat[ptr];
  assign seeded   = ~prbs | (fill > {1'b0, len});

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr <= '0;
      ptr  <= '0;
    end else if (bit_en) begin
      // while hunting the register tracks the line; when locked it free-runs
      lfsr <= {lfsr[PW-2:0], (load_rx ? rx_c : prbs_exp)};
      if (!slip) ptr <= (ptr >= len) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) fill <= '0;
    else if (bit_en && load_rx && (fill <= {1'b0, len})) fill <= fill + 1'b1;
  end

  // R4: a slip freezes the phase for one bit
  assert_slip_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (slip && !prbs && (ptr < len)) |=> (ptr == $past(ptr)));
endmodule

// File: rtl/pat_sync_fsm.sv
// Search / lock / hold control with run and window counters.
module pat_sync_fsm
  import pat_sync_pkg::*;
#(
  parameter int SYNC_RUN  = 48,
  parameter int WIN_LEN   = 48,
  parameter int ERR_LIMIT = 10,
  localparam int RW = $clog2(SYNC_RUN),
  localparam int WW = $clog2(WIN_LEN),
  localparam int EW = $clog2(ERR_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic mism,
  input  logic seeded,
  input  logic auto_sync,
  input  logic man_sync,
  output logic restart,
  output logic slip,
  output logic load_rx,
  output logic in_sync,
  output logic bit_err,
  output logic bit_chk
);
  det_state_e    state;
  logic [RW-1:0] run;
  logic [WW-1:0] win;
  logic [EW-1:0] errs;
  logic          man_q;
  logic          man_rise;
  logic          lose;

  assign man_rise = man_sync & ~man_q;
  assign lose     = (state == ST_LOCK) & bit_en & mism & (errs == EW'(ERR_LIMIT));
  assign restart  = man_rise | lose;
  assign slip     = (state == ST_HUNT) & bit_en & seeded & mism & ~man_rise;
  assign load_rx  = (state != ST_LOCK);
  assign in_sync  = (state == ST_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      run     <= '0;
      win     <= '0;
      errs    <= '0;
      man_q   <= 1'b0;
      bit_err <= 1'b0;
      bit_chk <= 1'b0;
    end else begin
      man_q   <= man_sync;
      bit_chk <= bit_en && (state == ST_LOCK);
      bit_err <= bit_en && (state == ST_LOCK) && mism;
      if (man_rise) begin
        state <= ST_HUNT;
        run   <= '0;
        win   <= '0;
        errs  <= '0;
      end else if (bit_en) begin
        case (state)
          ST_HUNT: if (seeded) begin
            if (mism) run <= '0;
            else if (run == RW'(SYNC_RUN - 1)) begin
              state <= ST_LOCK;
              run   <= '0;
              win   <= '0;
              errs  <= '0;
            end else run <= run + 1'b1;
          end
          ST_LOCK: if (lose) begin
            state <= auto_sync ? ST_HUNT : ST_HOLD;
            win   <= '0;
            errs  <= '0;
          end else if (win == WW'(WIN_LEN - 1)) begin
            win  <= '0;
            errs <= '0;
          end else begin
            win  <= win + 1'b1;
            errs <= errs + EW'(mism);
          end
          default: ;
        endcase
      end
    end
  end

  assert_lock_on_bit_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(in_sync) |-> $past(bit_en));
  assert_err_has_chk_R5: assert property (@(posedge clk) disable iff (rst)
    bit_err |-> bit_chk);
  assert_chk_from_lock_R5: assert property (@(posedge clk) disable iff (rst)
    bit_chk |-> $past(in_sync && bit_en));
  assert_err_bound_R6: assert property (@(posedge clk) disable iff (rst)
    errs <= EW'(ERR_LIMIT));
  assert_drop_with_err_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(in_sync) && !$past(man_rise)) |-> bit_err);
  assert_hold_stays_R9: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_HOLD) && !man_rise) |=> (state == ST_HOLD));
  assert_manual_restart_R10: assert property (@(posedge clk) disable iff (rst)
    man_rise |=> !in_sync);
  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && !man_rise) |=> $stable(state));
endmodule

// File: rtl/pat_sync_det.sv
module pat_sync_det #(
  parameter int PW        = 32,
  parameter int SYNC_RUN  = 48,
  parameter int WIN_LEN   = 48,
  parameter int ERR_LIMIT = 10,
  localparam int LW = $clog2(PW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          rx_bit,
  input  logic          cfg_prbs,
  input  logic [LW-1:0] cfg_len,
  input  logic [LW-1:0] cfg_tap,
  input  logic [PW-1:0] cfg_pat,
  input  logic          cfg_inv,
  input  logic          auto_sync,
  input  logic          man_sync,
  output logic          in_sync,
  output logic          bit_err,
  output logic          bit_chk
);
  logic rx_c, exp_bit, seeded, restart, slip_raw, load_rx;

  assign rx_c = rx_bit ^ cfg_inv;

  pat_sync_ref #(.PW(PW)) u_ref (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_c(rx_c),
    .prbs(cfg_prbs), .len(cfg_len), .tap(cfg_tap), .pat(cfg_pat),
    .load_rx(load_rx), .restart(restart), .slip(slip_raw & ~cfg_prbs),
    .exp_bit(exp_bit), .seeded(seeded)
  );

  pat_sync_fsm #(.SYNC_RUN(SYNC_RUN), .WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)) u_fsm (
    .clk(clk), .rst(rst), .bit_en(bit_en), .mism(rx_c ^ exp_bit),
    .seeded(seeded), .auto_sync(auto_sync), .man_sync(man_sync),
    .restart(restart), .slip(slip_raw), .load_rx(load_rx),
    .in_sync(in_sync), .bit_err(bit_err), .bit_chk(bit_chk)
  );
endmodule

// File: tb/test_pat_sync_det.sv
module test_pat_sync_det;
  localparam int PW = 32;
  localparam int LW = 5;
  // {prbs, len[4:0], tap[4:0], pat[31:0], inv}
  localparam logic [43:0] CFG_TAB [5] = '{
    {1'b1, 5'd6,  5'd5,  32'h0000_005A, 1'b0},
    {1'b1, 5'd14, 5'd13, 32'h0000_1234, 1'b1},
    {1'b1, 5'd1,  5'd0,  32'h0000_0001, 1'b0},
    {1'b0, 5'd7,  5'd0,  32'h0000_00B2, 1'b0},
    {1'b0, 5'd31, 5'd0,  32'hC3A5_0F96, 1'b1}
  };

  logic clk = 0, rst = 1, bit_en = 0, rx_bit = 0, cfg_prbs = 0;
  logic [LW-1:0] cfg_len = '0, cfg_tap = '0;
  logic [PW-1:0] cfg_pat = '0;
  logic cfg_inv = 0, auto_sync = 1, man_sync = 0;
  logic in_sync, bit_err, bit_chk;
  logic s_sync, s_err, s_chk, tx_inv = 0, done = 0;
  logic [PW-1:0] g_lfsr;
  int g_ptr, n_tests = 0, n_fail = 0, nb, bad;

  always #10 clk = ~clk;

  pat_sync_det i_pat_sync_det (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .cfg_prbs(cfg_prbs),
    .cfg_len(cfg_len), .cfg_tap(cfg_tap), .cfg_pat(cfg_pat), .cfg_inv(cfg_inv),
    .auto_sync(auto_sync), .man_sync(man_sync),
    .in_sync(in_sync), .bit_err(bit_err), .bit_chk(bit_chk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [43:0] v, input int phase);
    cfg_prbs = v[43]; cfg_len = v[42:38]; cfg_tap = v[37:33];
    cfg_pat = v[32:1]; cfg_inv = v[0]; tx_inv = v[0];
    g_lfsr = v[32:1]; g_ptr = phase;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; bit_en = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic gen(output logic b);
    if (cfg_prbs) begin
      b = g_lfsr[cfg_len] ^ g_lfsr[cfg_tap];
      g_lfsr = {g_lfsr[PW-2:0], b};
    end else begin
      b = cfg_pat[g_ptr];
      g_ptr = (g_ptr == int'(cfg_len)) ? 0 : g_ptr + 1;
    end
  endtask

  task automatic send(input logic b);
    @(negedge clk); rx_bit = b ^ tx_inv; bit_en = 1;
    @(negedge clk); bit_en = 0;
    s_sync = in_sync; s_err = bit_err; s_chk = bit_chk;
  endtask

  task automatic run_lock(input int maxb, output int n);
    logic b;
    n = 0;
    do begin gen(b); send(b); n++; end while (!s_sync && n < maxb);
  endtask

  task automatic run_clean(input int n, output int nbad);
    logic b;
    nbad = 0;
    for (int k = 0; k < n; k++) begin
      gen(b); send(b);
      if (!s_sync || !s_chk || s_err) nbad++;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic b;
    int e;
    // R1: reset state
    load_cfg(CFG_TAB[0], 0);
    do_reset();
    @(negedge clk);
    check(!in_sync && !bit_err && !bit_chk, "R1 reset outputs", in_sync, 0);

    // table walk: lock time and clean run per configuration (R2 R3 R4 R5)
    for (int i = 0; i < 5; i++) begin
      load_cfg(CFG_TAB[i], 0);
      do_reset();
      run_lock(400, nb);
      e = CFG_TAB[i][43] ? int'(CFG_TAB[i][42:38]) + 49 : 48;
      check(s_sync && nb == e, CFG_TAB[i][43] ? "R3 prbs lock time (R2 inv)" : "R4 repeat lock time (R2 inv)", nb, e);
      run_clean(60, bad);
      check(bad == 0, "R5 clean locked stream", bad, 0);
    end

    // R4: misaligned repeating stream finds its rotation
    load_cfg(CFG_TAB[3], 3);
    do_reset();
    run_lock(3000, nb);
    check(s_sync && nb >= 48, "R4 rotation search", nb, 48);
    run_clean(60, bad);
    check(bad == 0, "R4 rotation clean after lock", bad, 0);

    // R2: complemented stream without cfg_inv never locks
    load_cfg(CFG_TAB[3], 0);
    tx_inv = 1;
    do_reset();
    bad = 0;
    for (int k = 0; k < 300; k++) begin gen(b); send(b); if (s_sync) bad++; end
    check(bad == 0, "R2 no lock without inversion", bad, 0);

    // R11: idle cycles ignored, then R5 single error
    load_cfg(CFG_TAB[0], 0);
    do_reset();
    run_lock(400, nb);
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); rx_bit = ~rx_bit; bit_en = 0;
      @(negedge clk);
      if (bit_chk || bit_err || !in_sync) bad++;
    end
    run_clean(20, nb);
    check(bad == 0 && nb == 0, "R11 strobe-low cycles ignored", bad + nb, 0);
    gen(b); send(~b);
    check(s_err && s_chk && s_sync, "R5 single error pulse", s_err, 1);
    run_clean(48, bad);
    check(bad == 0, "R5 no error propagation", bad, 0);

    // R6 R7: window boundaries and loss, R8 auto relock
    do_reset();
    load_cfg(CFG_TAB[0], 0);
    run_lock(400, nb);
    bad = 0;
    for (int k = 0; k < 155; k++) begin
      logic in_e;
      in_e = (k <= 9) || (k >= 90 && k <= 101) || (k >= 144);
      gen(b); send(in_e ? ~b : b);
      if (k < 154 && (s_err != in_e || !s_sync || !s_chk)) bad++;
    end
    check(bad == 0, "R6 ten errors and split windows keep lock", bad, 0);
    check(s_err && !s_sync, "R7 eleventh error drops lock same cycle", s_sync, 0);
    run_lock(400, nb);
    check(s_sync && nb == 55, "R8 automatic relock", nb, 55);

    // R9 R10: manual mode
    auto_sync = 0;
    do_reset();
    load_cfg(CFG_TAB[0], 0);
    run_lock(400, nb);
    for (int k = 0; k < 11; k++) begin gen(b); send(~b); end
    check(!s_sync, "R9 loss with auto off", s_sync, 0);
    bad = 0;
    for (int k = 0; k < 200; k++) begin gen(b); send(b); if (s_sync) bad++; end
    check(bad == 0, "R9 stays unlocked without manual edge", bad, 0);
    @(negedge clk); man_sync = 1;
    run_lock(400, nb);
    check(s_sync && nb == 55, "R10 manual edge relock", nb, 55);
    run_clean(100, bad);
    check(bad == 0, "R10 held level has no effect", bad, 0);
    @(negedge clk); man_sync = 0;
    run_clean(5, bad);
    @(negedge clk); man_sync = 1;
    @(negedge clk);
    check(!in_sync && bad == 0, "R10 manual edge drops lock", in_sync, 0);
    man_sync = 0;
    run_lock(400, nb);
    check(s_sync && nb == 55, "R10 relock after manual edge", nb, 55);

    // R1: reset while locked
    @(negedge clk); rst = 1;
    @(negedge clk);
    check(!in_sync && !bit_chk && !bit_err, "R1 reset clears lock", in_sync, 0);
    rst = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule